// File: doc/BRIEF.md
# Time-Shared Multipath Despreading Engine

This block despreads several multipath copies of one received signal using a single shared correlator. Complex baseband samples arrive at a fixed number of samples per chip. Each sample is written into a circular buffer that is long enough to span the whole delay spread. When the last sample of a chip arrives, the engine steps through the fingers one per clock cycle. For each enabled finger it reads the buffered sample at that finger's programmed delay behind the newest sample. It applies that finger's ±1 code chip by negating or passing the sample, and adds the result into the finger's integrator.

After a fixed number of chips the symbol is complete. The engine then walks the fingers again in ascending order. It pushes each enabled finger's integrated I/Q pair into an output symbol queue, tagged with the finger index, and clears the integrators. Finger enable and delay settings are written at any time into a pending copy. That copy becomes active only at the end of a symbol, so no integration ever mixes two settings.

The control state machine has four states. IDLE waits for a chip end. SCAN serves one finger per cycle. DUMP pushes one finger per cycle into the queue. APPLY copies the pending settings into the active set. The transitions are:
- chip-end: IDLE to SCAN
- next-finger: SCAN to SCAN
- chip-done: SCAN to IDLE, after the last finger of a chip that does not end a symbol
- symbol-done: SCAN to DUMP, after the last finger of the final chip of a symbol
- next-dump: DUMP to DUMP
- dumps-done: DUMP to APPLY
- settings-applied: APPLY to IDLE

Top module: `rake_despreader`

## Requirements
- R1: After reset the output queue is empty (`out_valid` low), every finger is disabled, every integrator holds zero and every buffer entry holds zero.
- R2: The n-th accepted sample (counting from 0 after reset) is stored at buffer address n modulo `BUF_DEPTH`, overwriting the entry from `BUF_DEPTH` samples earlier.
- R3: Every `SPC`-th accepted sample (sample index n with n mod `SPC` = `SPC`-1) ends a chip. For that chip each enabled finger with delay d reads the sample of index n-d, so delay 0 selects the chip's last sample. A delay reaching back before the first sample reads zero.
- R4: `chip_code` is captured together with the chip's last sample. Bit k equal to 1 negates both I and Q of finger k's sample; bit k equal to 0 adds the sample unchanged.
- R5: After `SF` chips the symbol ends. The integrated I/Q of every enabled finger is pushed into the output queue in ascending finger order, with the finger index on `out_finger`, and all integrators restart from zero.
- R6: A disabled finger adds nothing to its integrator and pushes no entry at the end of a symbol.
- R7: A settings write (`cfg_we` with `cfg_idx`, `cfg_en`, `cfg_delay`) takes effect only at the next symbol end, after that symbol's dumps. The symbol in progress is integrated and dumped with the old settings.
- R8: The integrators are `SW + clog2(SF) + 1` bits wide, so a full symbol of the most negative sample value with every chip negated gives +`SF`·2^(`SW`-1) without wrapping.
- R9: The output queue holds `FIFO_DEPTH` entries and presents its oldest entry on the output ports while `out_valid` is high. An entry is removed on a cycle with `out_valid` and `out_ready` both high. A dump that finds the queue full is discarded and the stored entries are unchanged.
- R10: Operating limits are that chip ends are at least 2·`NUM_FINGERS`+2 cycles apart and that every delay is at most `BUF_DEPTH`-`SPC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_i | input | SW | In-phase sample, two's complement |
| smp_q | input | SW | Quadrature sample, two's complement |
| chip_code | input | NUM_FINGERS | Per-finger code chip, 1 = negate; captured with a chip's last sample |
| cfg_we | input | 1 | Write the pending settings of one finger |
| cfg_idx | input | clog2(NUM_FINGERS) | Finger addressed by the write |
| cfg_en | input | 1 | Pending enable for that finger |
| cfg_delay | input | clog2(BUF_DEPTH) | Pending delay in samples for that finger |
| out_valid | output | 1 | Output queue is not empty |
| out_ready | input | 1 | Consumer takes the presented entry |
| out_finger | output | clog2(NUM_FINGERS) | Finger index of the presented entry |
| out_i | output | SW+clog2(SF)+1 | Integrated in-phase result |
| out_q | output | SW+clog2(SF)+1 | Integrated quadrature result |

## Verification
The hardest case to reach is a settings write that lands in the middle of a symbol. That symbol has to be dumped with the old settings, and the new ones must start at a clean symbol edge. The stimulus reaches this by writing new delays and enables between two symbols, waiting until the previous boundary is safely over, and then checking the next two symbols' dumps against a model that keeps separate pending and active copies. A second case that is hard to reach is a full queue. It is produced by holding `out_ready` low for three whole symbols, so the third symbol's dumps hit a full queue and must vanish without disturbing the stored ones.

// File: rtl/rake_pkg.sv
package rake_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DUMP  = 2'd2,
        ST_APPLY = 2'd3
    } eng_state_t;

endpackage

// File: rtl/rake_sample_ring.sv
module rake_sample_ring #(
    parameter int DEPTH = 64,
    parameter int SW    = 8,
    parameter int AW    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic signed [SW-1:0] wr_i,
    input  logic signed [SW-1:0] wr_q,
    output logic [AW-1:0]        wr_addr,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [SW-1:0] rd_i,
    output logic signed [SW-1:0] rd_q
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic signed [SW-1:0] store_i [DEPTH];
    logic signed [SW-1:0] store_q [DEPTH];
    logic [AW-1:0]        wptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                store_i[k] <= '0;
                store_q[k] <= '0;
            end
        end else if (wr_en) begin
            store_i[wptr] <= wr_i;
            store_q[wptr] <= wr_q;
            wptr          <= (wptr == LAST_ADDR) ? '0 : wptr + 1'b1;
        end
    end

    assign wr_addr = wptr;
    assign rd_i    = store_i[rd_addr];
    assign rd_q    = store_q[rd_addr];

    // R2: the write pointer steps by one per sample and wraps at the buffer depth
    a_r2_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wptr == (($past(wptr) == LAST_ADDR) ? '0 : $past(wptr) + 1'b1)));

    a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wptr));

endmodule

// File: rtl/rake_finger_cfg.sv
module rake_finger_cfg #(
    parameter int NF = 4,
    parameter int FW = 2,
    parameter int AW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [FW-1:0]          wr_idx,
    input  logic                   wr_on,
    input  logic [AW-1:0]          wr_delay,
    input  logic                   apply,
    output logic [NF-1:0]          act_en,
    output logic [NF-1:0][AW-1:0]  act_delay
);

    logic [NF-1:0]         pend_en;
    logic [NF-1:0][AW-1:0] pend_delay;

    for (genvar g = 0; g < NF; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_en[g]    <= 1'b0;
                pend_delay[g] <= '0;
            end else if (wr_en && (wr_idx == FW'(g))) begin
                pend_en[g]    <= wr_on;
                pend_delay[g] <= wr_delay;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_en[g]    <= 1'b0;
                act_delay[g] <= '0;
            end else if (apply) begin
                act_en[g]    <= pend_en[g];
                act_delay[g] <= pend_delay[g];
            end
        end
    end

    // R7: active settings move only on the boundary strobe
    a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(act_en) && $stable(act_delay)));

endmodule

// File: rtl/rake_sym_fifo.sv
module rake_sym_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic          full,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] dout
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign valid   = (cnt != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = slots[rp];

    always_ff @(posedge clk) begin
        if (do_push) slots[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R9: a full queue without a pop stays full and keeps its head
    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (full && $stable(dout)));

    a_r9_never_over: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/rake_despreader.sv
module rake_despreader #(
    parameter int NUM_FINGERS = 4,
    parameter int SPC         = 4,
    parameter int BUF_DEPTH   = 64,
    parameter int SW          = 8,
    parameter int SF          = 8,
    parameter int FIFO_DEPTH  = 8,
    localparam int FW    = (NUM_FINGERS > 1) ? $clog2(NUM_FINGERS) : 1,
    localparam int AW    = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int ACC_W = SW + ((SF > 1) ? $clog2(SF) : 1) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [SW-1:0]          smp_i,
    input  logic [SW-1:0]          smp_q,
    input  logic [NUM_FINGERS-1:0] chip_code,
    input  logic                   cfg_we,
    input  logic [FW-1:0]          cfg_idx,
    input  logic                   cfg_en,
    input  logic [AW-1:0]          cfg_delay,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [FW-1:0]          out_finger,
    output logic [ACC_W-1:0]       out_i,
    output logic [ACC_W-1:0]       out_q
);
    import rake_pkg::*;

    localparam int PHW = (SPC > 1) ? $clog2(SPC) : 1;
    localparam int CHW = (SF > 1) ? $clog2(SF) : 1;
    localparam int DW  = FW + 2 * ACC_W;
    localparam logic [PHW-1:0] PH_LAST   = PHW'(SPC - 1);
    localparam logic [CHW-1:0] CHIP_LAST = CHW'(SF - 1);
    localparam logic [FW-1:0]  F_LAST    = FW'(NUM_FINGERS - 1);
    localparam logic [AW:0]    DEPTH_X   = (AW + 1)'(BUF_DEPTH);

    // ---------------- sample buffer ----------------
    logic [AW-1:0]        wr_addr, rd_addr;
    logic signed [SW-1:0] rd_i, rd_q;

    rake_sample_ring #(.DEPTH(BUF_DEPTH), .SW(SW), .AW(AW)) ring_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (smp_valid),
        .wr_i    (smp_i),
        .wr_q    (smp_q),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .rd_i    (rd_i),
        .rd_q    (rd_q)
    );

    // ---------------- finger settings ----------------
    logic                           apply;
    logic [NUM_FINGERS-1:0]         act_en;
    logic [NUM_FINGERS-1:0][AW-1:0] act_delay;

    rake_finger_cfg #(.NF(NUM_FINGERS), .FW(FW), .AW(AW)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_on     (cfg_en),
        .wr_delay  (cfg_delay),
        .apply     (apply),
        .act_en    (act_en),
        .act_delay (act_delay)
    );

    // ---------------- chip timing ----------------
    logic [PHW-1:0] phase_q;
    logic           chip_done;

    assign chip_done = smp_valid && (phase_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         phase_q <= '0;
        else if (smp_valid) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
    end

    // ---------------- control state machine ----------------
    eng_state_t             state_q, state_d;
    logic [FW-1:0]          fidx_q;
    logic [CHW-1:0]         chip_cnt_q;
    logic [AW-1:0]          base_q;
    logic [NUM_FINGERS-1:0] code_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (chip_done) state_d = ST_SCAN;
            ST_SCAN:  if (fidx_q == F_LAST)
                          state_d = (chip_cnt_q == CHIP_LAST) ? ST_DUMP : ST_IDLE;
            ST_DUMP:  if (fidx_q == F_LAST) state_d = ST_APPLY;
            ST_APPLY: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fidx_q     <= '0;
            chip_cnt_q <= '0;
            base_q     <= '0;
            code_q     <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    fidx_q <= '0;
                    if (chip_done) begin
                        base_q <= wr_addr;
                        code_q <= chip_code;
                    end
                end
                ST_SCAN: begin
                    if (fidx_q == F_LAST) begin
                        fidx_q     <= '0;
                        chip_cnt_q <= (chip_cnt_q == CHIP_LAST) ? '0 : chip_cnt_q + 1'b1;
                    end else begin
                        fidx_q <= fidx_q + 1'b1;
                    end
                end
                ST_DUMP:  fidx_q <= (fidx_q == F_LAST) ? '0 : fidx_q + 1'b1;
                ST_APPLY: fidx_q <= '0;
            endcase
        end
    end

    // ---------------- offset address and correlator ----------------
    logic [AW:0]             base_x, dly_x, rd_x;
    logic signed [ACC_W-1:0] ext_i, ext_q, prod_i, prod_q, sum_i, sum_q;
    logic signed [ACC_W-1:0] acc_i [NUM_FINGERS];
    logic signed [ACC_W-1:0] acc_q [NUM_FINGERS];
    logic signed [ACC_W-1:0] sel_i, sel_q;

    assign base_x  = {1'b0, base_q};
    assign dly_x   = {1'b0, act_delay[fidx_q]};
    assign rd_x    = (base_x >= dly_x) ? (base_x - dly_x) : (base_x + DEPTH_X - dly_x);
    assign rd_addr = rd_x[AW-1:0];

    assign ext_i  = ACC_W'(rd_i);
    assign ext_q  = ACC_W'(rd_q);
    assign prod_i = code_q[fidx_q] ? -ext_i : ext_i;
    assign prod_q = code_q[fidx_q] ? -ext_q : ext_q;
    assign sel_i  = acc_i[fidx_q];
    assign sel_q  = acc_q[fidx_q];
    assign sum_i  = sel_i + prod_i;
    assign sum_q  = sel_q + prod_q;

    // ---------------- per-state outputs ----------------
    logic          acc_add, acc_clr, dump_push, fifo_full;
    logic [DW-1:0] dump_word, head_word;

    always_comb begin
        acc_add   = 1'b0;
        acc_clr   = 1'b0;
        dump_push = 1'b0;
        apply     = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SCAN:  acc_add = act_en[fidx_q];
            ST_DUMP: begin
                acc_clr   = 1'b1;
                dump_push = act_en[fidx_q] && !fifo_full;
            end
            ST_APPLY: apply = 1'b1;
        endcase
    end

    assign dump_word = {fidx_q, sel_i, sel_q};

    for (genvar g = 0; g < NUM_FINGERS; g++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_i[g] <= '0;
                acc_q[g] <= '0;
            end else if (fidx_q == FW'(g)) begin
                if (acc_add) begin
                    acc_i[g] <= sum_i;
                    acc_q[g] <= sum_q;
                end else if (acc_clr) begin
                    acc_i[g] <= '0;
                    acc_q[g] <= '0;
                end
            end
        end
    end

    // ---------------- symbol queue ----------------
    rake_sym_fifo #(.DEPTH(FIFO_DEPTH), .DW(DW)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dump_push),
        .din   (dump_word),
        .full  (fifo_full),
        .pop   (out_ready),
        .valid (out_valid),
        .dout  (head_word)
    );

    assign out_finger = head_word[DW-1 -: FW];
    assign out_i      = head_word[2*ACC_W-1 -: ACC_W];
    assign out_q      = head_word[ACC_W-1:0];

    // ---------------- assertions ----------------
    // R10: a chip end must find the engine idle
    a_r10_chip_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        chip_done |-> (state_q == ST_IDLE));

    // R5: dumps walk the fingers in ascending order, one per cycle
    a_r5_dump_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUMP && fidx_q != F_LAST) |=>
            (state_q == ST_DUMP && fidx_q == $past(fidx_q) + 1'b1));

    // R8: integration never wraps the sign
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_add && (sel_i[ACC_W-1] == prod_i[ACC_W-1]))
            |-> (sum_i[ACC_W-1] == prod_i[ACC_W-1]));

    // R6: a disabled finger's integrator does not move during a scan
    a_r6_idle_finger: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && !act_en[fidx_q]) |=>
            (acc_i[$past(fidx_q)] == $past(sel_i)));

    // R7: settings are applied only straight after the dump walk
    a_r7_apply_after_dump: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> ($past(state_q) == ST_DUMP));

endmodule

// File: tb/rake_despreader_tb_top.sv
module rake_despreader_tb_top;

    localparam int NF    = 4;
    localparam int SPC   = 4;
    localparam int DEPTH = 64;
    localparam int SW    = 8;
    localparam int SF    = 8;
    localparam int FD    = 8;
    localparam int FW    = 2;
    localparam int AW    = 6;
    localparam int ACC_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [SW-1:0]     smp_i = '0, smp_q = '0;
    logic [NF-1:0]     chip_code = '0;
    logic              cfg_we = 1'b0;
    logic [FW-1:0]     cfg_idx = '0;
    logic              cfg_en = 1'b0;
    logic [AW-1:0]     cfg_delay = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [FW-1:0]     out_finger;
    logic [ACC_W-1:0]  out_i, out_q;

    rake_despreader #(
        .NUM_FINGERS(NF), .SPC(SPC), .BUF_DEPTH(DEPTH),
        .SW(SW), .SF(SF), .FIFO_DEPTH(FD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .chip_code(chip_code), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
        .cfg_delay(cfg_delay), .out_valid(out_valid), .out_ready(out_ready),
        .out_finger(out_finger), .out_i(out_i), .out_q(out_q)
    );

    always #4 clk = ~clk;

    int    errs = 0;
    int    checks = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // behavioural reference
    typedef struct { int f; int vi; int vq; } dump_t;
    int    hist_i[$], hist_q[$];
    int    m_acc_i[NF], m_acc_q[NF];
    bit    m_en[NF], p_en[NF];
    int    m_dly[NF], p_dly[NF];
    int    m_chip = 0;
    dump_t mq[$];

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic send(int si, int sq, logic [NF-1:0] code);
        int n;
        @(posedge clk); #1;
        smp_valid = 1'b1;
        smp_i     = si[SW-1:0];
        smp_q     = sq[SW-1:0];
        chip_code = code;
        n = hist_i.size();
        hist_i.push_back(si);
        hist_q.push_back(sq);
        if ((n % SPC) == SPC - 1) begin
            for (int f = 0; f < NF; f++) begin
                if (m_en[f]) begin
                    int idx, vi, vq;
                    idx = n - m_dly[f];
                    vi = (idx >= 0) ? hist_i[idx] : 0;
                    vq = (idx >= 0) ? hist_q[idx] : 0;
                    if (code[f]) begin vi = -vi; vq = -vq; end
                    m_acc_i[f] += vi;
                    m_acc_q[f] += vq;
                end
            end
            m_chip++;
            if (m_chip == SF) begin
                for (int f = 0; f < NF; f++) begin
                    if (m_en[f] && mq.size() < FD) begin
                        dump_t d;
                        d.f = f; d.vi = m_acc_i[f]; d.vq = m_acc_q[f];
                        mq.push_back(d);
                    end
                    m_acc_i[f] = 0;
                    m_acc_q[f] = 0;
                    m_en[f]  = p_en[f];
                    m_dly[f] = p_dly[f];
                end
                m_chip = 0;
            end
        end
        @(posedge clk); #1;
        smp_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic send_symbol_rand();
        for (int k = 0; k < SF * SPC; k++)
            send(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
                 NF'($urandom_range(0, 15)));
    endtask

    task automatic send_symbol_const(int si, int sq, logic [NF-1:0] code);
        for (int k = 0; k < SF * SPC; k++) send(si, sq, code);
    endtask

    // settings writes are issued well after any boundary, i.e. inside a symbol
    task automatic cfg_write(int f, bit en, int dly);
        repeat (12) @(posedge clk);
        #1;
        cfg_we = 1'b1; cfg_idx = FW'(f); cfg_en = en; cfg_delay = AW'(dly);
        p_en[f] = en; p_dly[f] = dly;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // output comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (mq.size() == 0) begin
                check_eq(cur_req, "unexpected dump finger", int'(out_finger), -1);
            end else begin
                dump_t e;
                e = mq.pop_front();
                check_eq(cur_req, "finger", int'(out_finger), e.f);
                check_eq(cur_req, "I", int'($signed(out_i)), e.vi);
                check_eq(cur_req, "Q", int'($signed(out_q)), e.vq);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int f = 0; f < NF; f++) begin
            m_acc_i[f] = 0; m_acc_q[f] = 0; m_en[f] = 0; p_en[f] = 0;
            m_dly[f] = 0; p_dly[f] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: empty queue after reset
        check_eq("R1", "out_valid after reset", int'(out_valid), 0);

        // R1, R6: with every finger disabled a full symbol yields nothing
        send_symbol_rand();
        repeat (20) @(negedge clk);
        check_eq("R1", "out_valid with no finger enabled", int'(out_valid), 0);

        // R7: settings written now must not act until this symbol ends
        cur_req = "R7";
        send(5, -3, 4'b0000);
        cfg_write(0, 1, 0);
        cfg_write(1, 1, 1);
        cfg_write(2, 1, 5);
        cfg_write(3, 1, 13);
        for (int k = 1; k < SF * SPC; k++) send(7, 2, 4'b0101);
        repeat (20) @(negedge clk);
        check_eq("R7", "no dump from the symbol before apply", int'(out_valid), 0);

        // R3, R4, R5: varied data, codes and delays
        cur_req = "R3_R4_R5";
        for (int s = 0; s < 4; s++) send_symbol_rand();

        // R6, R7: disable finger 2 and move finger 0 to the deepest delay mid-symbol
        cur_req = "R6_R7";
        send(11, 12, 4'b1111);
        cfg_write(2, 0, 7);
        cfg_write(0, 1, DEPTH - SPC);
        for (int k = 1; k < SF * SPC; k++)
            send(int'($urandom_range(0, 255)) - 128, int'($urandom_range(0, 255)) - 128,
                 NF'($urandom_range(0, 15)));
        for (int s = 0; s < 3; s++) send_symbol_rand();   // R2: buffer wraps many times

        // R8: extreme values on every finger
        cur_req = "R8";
        cfg_write(0, 1, 0);
        cfg_write(1, 1, 0);
        cfg_write(2, 1, 0);
        cfg_write(3, 1, 3);
        send_symbol_const(-128, 127, 4'b0000);
        send_symbol_const(-128, -128, 4'b1111);
        send_symbol_const(127, -128, 4'b0000);
        send_symbol_const(-128, 127, 4'b1010);
        repeat (20) @(negedge clk);

        // R9: hold the consumer off for three symbols; the third is discarded
        cur_req = "R9";
        @(posedge clk); #1 out_ready = 1'b0;
        for (int s = 0; s < 3; s++) send_symbol_rand();
        repeat (20) @(negedge clk);
        check_eq("R9", "queue still valid while stalled", int'(out_valid), 1);
        check_eq("R9", "model backlog equals depth", mq.size(), FD);
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (FD + 10) @(negedge clk);
        check_eq("R9", "queue drained", int'(out_valid), 0);
        check_eq("R9", "no expected dump left", mq.size(), 0);

        // R5: one more symbol after the drain, then final drain
        cur_req = "R5";
        send_symbol_rand();
        repeat (30) @(negedge clk);
        check_eq("R5", "all expected dumps seen", mq.size(), 0);
        finish_run();
    end

endmodule